// File: doc/BRIEF.md
# Address Decoder Sweep Mapper

This block builds the memory map of an unknown combinational chip-select decoder without any processor. Once armed, it walks a binary count across the decoder's address inputs, one value per step. While it does so it holds the read/write strobe at read. After each address change it waits a programmable number of settle cycles and then samples the decoder's select outputs. A record is emitted only where the sampled pattern differs from the one sampled at the previous address. The records therefore list region boundaries: the first address of each region and the select pattern that holds inside it.

The swept lines may be any contiguous subset of a wider bus. A typical case is the eleven upper lines of a 16-bit bus, with the lower lines left undriven. The address drivers stay disabled until the block is armed, so it can sit on a board beside other bus masters without contention. Records leave through a valid/ready handshake. When the consumer is slow, the sweep stalls on its current address, so no boundary is ever lost. A sweep either stops at the all-ones address or, in continuous mode, wraps to zero and repeats.

Top module: `sweep_mapper`

## Requirements
- R1: While `arm` is low, `addr_oe` is 0 and `done` is 0. `addr_oe` drops at the first clock edge that sees `arm` low, and any pending record is withdrawn at that edge.
- R2: `rw_n` is 1 (read) at all times, in reset and in every state.
- R3: Once armed, `addr_out` starts at 0. Each change of `addr_out` while the drivers are enabled is an increment by one, modulo 2^ADDR_W, so every address is visited exactly once per sweep.
- R4: The first address of every sweep (address 0) always yields a record that carries the select pattern sampled there.
- R5: At any later address, a record is produced exactly when the sampled `cs_in` differs from the value sampled at the previous address. The record's `rec_addr` is that address and its `rec_cs` is the new pattern.
- R6: `cs_in` is sampled at the clock edge `settle_cycles`+1 cycles after the edge that changed `addr_out`, or after the edge that enabled the drivers. The address is therefore stable for `settle_cycles`+1 clock periods before each sample.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, `rec_valid`, `rec_addr`, `rec_cs` and `addr_out` all hold. A record is transferred at an edge where both `rec_valid` and `rec_ready` are 1.
- R8: Once the all-ones address has been sampled and any record for it has been accepted, `done` rises. In single mode (`continuous`=0), `addr_out` then holds all ones with `addr_oe` still 1, no further record appears, and `done` stays 1 until `arm` drops.
- R9: In continuous mode (`continuous`=1), the sweep wraps from all ones to 0 and starts again with a fresh first record at address 0. `done` stays 1 from the end of the first sweep onwards.
- R10: After synchronous reset, `addr_oe`, `rec_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Enables the drivers and runs the sweep while high |
| continuous | input | 1 | 1: wrap and repeat sweeps; 0: stop after one sweep |
| settle_cycles | input | SETTLE_W | Extra settle cycles before each sample (typical 2) |
| addr_out | output | ADDR_W | Swept address value |
| addr_oe | output | 1 | Driver enable for `addr_out` and `rw_n` (0 = high impedance) |
| rw_n | output | 1 | Read/write strobe, constant read (1) |
| cs_in | input | CS_W | Select outputs of the decoder under test |
| rec_valid | output | 1 | Boundary record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_addr | output | ADDR_W | First address of the new region |
| rec_cs | output | CS_W | Select pattern of the new region |
| done | output | 1 | All-ones address has been sampled |

## Verification
The assertions assume three things about the inputs. `settle_cycles` and `continuous` stay constant while armed. `arm` is not dropped while a record is waiting unless that record is meant to be discarded. `cs_in` is a settled function of `addr_out` by the time it is sampled. The bench keeps within these limits: it changes the configuration only between runs, with `arm` low, and it ends a continuous run only after the records it checks have been taken. Its decoder model deliberately returns the inverted pattern until the address has been stable for the programmed settle time. An early sample therefore shows up as a wrong record, while a correct design never sees the inverted value.

// File: rtl/smap_pkg.sv
package smap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_EMIT   = 2'd2,
    ST_DONE   = 2'd3
  } smap_state_t;
endpackage

// File: rtl/smap_addr_gen.sv
// Binary up-counter for the swept address lines.
module smap_addr_gen #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] addr,
  output logic         at_last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (step)  addr <= addr + ONE;
  end

  assign at_last = &addr;
endmodule

// File: rtl/smap_settle_timer.sv
// Counts cycles since the last address change; hit marks the sample edge.
module smap_settle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] settle_cycles,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = (cnt >= settle_cycles);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!hit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/smap_record_unit.sv
// Change detector and output record register with valid/ready hold.
module smap_record_unit #(
  parameter int AW = 11,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          sample,
  input  logic          force_rec,
  input  logic [SW-1:0] cs_in,
  input  logic [AW-1:0] addr,
  input  logic          rec_ready,
  output logic          emit,
  output logic          rec_valid,
  output logic [AW-1:0] rec_addr,
  output logic [SW-1:0] rec_cs
);
  logic [SW-1:0] prev_cs;

  assign emit = sample && (force_rec || (cs_in != prev_cs));

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_cs    <= '0;
      prev_cs   <= '0;
    end else begin
      if (abort) begin
        rec_valid <= 1'b0;
      end else if (emit) begin
        rec_valid <= 1'b1;
        rec_addr  <= addr;
        rec_cs    <= cs_in;
      end else if (rec_valid && rec_ready) begin
        rec_valid <= 1'b0;
      end
      if (sample) prev_cs <= cs_in;
    end
  end

  // R7: a record waiting on its consumer keeps its content
  p_rec_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready && !abort) |=>
      (rec_valid && $stable(rec_addr) && $stable(rec_cs)));

  // R7: no new record is taken while one is still pending
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !sample);
endmodule

// File: rtl/sweep_mapper.sv
module sweep_mapper
  import smap_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int CS_W     = 4,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic                continuous,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [ADDR_W-1:0]   addr_out,
  output logic                addr_oe,
  output logic                rw_n,
  input  logic [CS_W-1:0]     cs_in,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [ADDR_W-1:0]   rec_addr,
  output logic [CS_W-1:0]     rec_cs,
  output logic                done
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  smap_state_t state;
  logic first_q;
  logic at_last, hit, emit;
  logic start, sample, accept, advance, step, timer_clr;

  assign start     = arm && (state == ST_IDLE);
  assign sample    = arm && (state == ST_SETTLE) && hit;
  assign accept    = arm && (state == ST_EMIT) && rec_valid && rec_ready;
  assign advance   = (sample && !emit) || accept;
  assign step      = advance && (!at_last || continuous);
  assign timer_clr = !arm || (state != ST_SETTLE) || sample;

  smap_addr_gen #(.W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .step    (step),
    .addr    (addr_out),
    .at_last (at_last)
  );

  smap_settle_timer #(.CW(SETTLE_W)) u_settle (
    .clk           (clk),
    .rst           (rst),
    .clr           (timer_clr),
    .settle_cycles (settle_cycles),
    .hit           (hit)
  );

  smap_record_unit #(.AW(ADDR_W), .SW(CS_W)) u_rec (
    .clk       (clk),
    .rst       (rst),
    .abort     (!arm),
    .sample    (sample),
    .force_rec (first_q),
    .cs_in     (cs_in),
    .addr      (addr_out),
    .rec_ready (rec_ready),
    .emit      (emit),
    .rec_valid (rec_valid),
    .rec_addr  (rec_addr),
    .rec_cs    (rec_cs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      first_q <= 1'b0;
      done    <= 1'b0;
      addr_oe <= 1'b0;
      rw_n    <= 1'b1;
    end else begin
      rw_n <= 1'b1;
      if (!arm) begin
        state   <= ST_IDLE;
        first_q <= 1'b0;
        done    <= 1'b0;
        addr_oe <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state   <= ST_SETTLE;
            first_q <= 1'b1;
            addr_oe <= 1'b1;
          end
          ST_SETTLE: begin
            if (sample) begin
              first_q <= 1'b0;
              if (emit) state <= ST_EMIT;
            end
          end
          ST_EMIT: ;
          ST_DONE: ;
          default: state <= ST_IDLE;
        endcase
        if (advance) begin
          if (at_last) begin
            done <= 1'b1;
            if (continuous) begin
              state   <= ST_SETTLE;
              first_q <= 1'b1;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            state <= ST_SETTLE;
          end
        end
      end
    end
  end

  // R1: drivers are released at the first edge that sees arm low
  p_oe_off_r1: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (!addr_oe && !done));

  // R3: the address only ever moves forward by one while driven
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_oe && $past(addr_oe) && (addr_out != $past(addr_out))) |->
      (addr_out == ($past(addr_out) + ADDR_ONE)));

  // R7: the sweep stalls on its address while a record waits
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (arm && rec_valid && !rec_ready) |=> $stable(addr_out));

  // R8: done is sticky while armed
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (done && arm) |=> done);

  // R8: a stopped sweep offers no record
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> !rec_valid);
endmodule

// File: tb/test_sweep_mapper.sv
module test_sweep_mapper;
  localparam int AW = 11;
  localparam int CW = 4;
  localparam int SW = 4;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic continuous = 1'b0;
  logic [SW-1:0] settle_cycles = 4'd2;
  logic [AW-1:0] addr_out;
  logic addr_oe, rw_n;
  logic [CW-1:0] cs_in = '0;
  logic rec_valid;
  logic rec_ready = 1'b0;
  logic [AW-1:0] rec_addr;
  logic [CW-1:0] rec_cs;
  logic done;

  int tests = 0;
  int fails = 0;
  int mode = 0;
  int unsigned key = 0;
  int ready_pct = 100;
  int got = 0;
  logic [AW+CW-1:0] exp_q[$];

  always #4 clk = ~clk;

  sweep_mapper #(.ADDR_W(AW), .CS_W(CW), .SETTLE_W(SW)) i_sweep_mapper (
    .clk(clk), .rst(rst), .arm(arm), .continuous(continuous),
    .settle_cycles(settle_cycles), .addr_out(addr_out), .addr_oe(addr_oe),
    .rw_n(rw_n), .cs_in(cs_in), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_addr(rec_addr), .rec_cs(rec_cs), .done(done)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, expv);
    end
  endtask

  function automatic logic [CW-1:0] dec(input logic [AW-1:0] a, input int m, input int unsigned k);
    logic [31:0] h;
    case (m)
      0: begin
        if (a < 11'd1024)      return 4'b0000;
        else if (a < 11'd1280) return 4'b0001;
        else if (a < 11'd1536) return 4'b0010;
        else if (a < 11'd1792) return 4'b0000;
        else if (a < 11'd2046) return 4'b0100;
        else if (a == 11'd2046) return 4'b1000;
        else                   return 4'b1100;
      end
      1: begin
        h = (32'(a) >> 5) * 32'h9E3779B1;
        h = h ^ k;
        return h[7:4];
      end
      default: return 4'b0101;
    endcase
  endfunction

  task automatic build_expected();
    logic [CW-1:0] p, c;
    exp_q.delete();
    p = '0;
    for (int a = 0; a < NADDR; a++) begin
      c = dec(AW'(a), mode, key);
      if (a == 0 || c != p) exp_q.push_back({AW'(a), c});
      p = c;
    end
  endtask

  // Decoder model, port monitors and record scoreboard, evaluated after each edge
  logic [AW-1:0] last_addr = '0;
  logic last_oe = 1'b0;
  int sc = 0;
  logic v_p = 1'b0;
  logic [AW-1:0] ra_p = '0, ad_p = '0;
  logic [CW-1:0] rc_p = '0;
  always @(posedge clk) begin
    logic changed;
    logic [AW-1:0] nxt;
    logic [AW+CW-1:0] e;
    #1;
    chk(rw_n == 1'b1, "R2 rw_n not read", rw_n, 1);
    if (rst) begin
      sc = 0; last_oe = 1'b0; v_p = 1'b0;
    end else begin
      changed = (addr_out != last_addr) || (addr_oe && !last_oe);
      if (!addr_oe || changed) sc = 0;
      else if (sc < 1000) sc++;
      nxt = last_addr + 1'b1;
      if (addr_oe && last_oe && addr_out != last_addr)
        chk(addr_out == nxt, "R3 address step", addr_out, nxt);
      if (!arm) chk(!addr_oe && !done, "R1 drivers off while unarmed", {addr_oe, done}, 0);
      if (v_p && !rec_ready && arm)
        chk(rec_valid && rec_addr == ra_p && rec_cs == rc_p && addr_out == ad_p,
            "R7 stall hold", {rec_valid, rec_addr, rec_cs}, {1'b1, ra_p, rc_p});
      if (v_p && rec_ready && arm) begin
        e = exp_q[got % exp_q.size()];
        if (got % exp_q.size() == 0)
          chk({ra_p, rc_p} == e, "R4 R9 first record of sweep", {ra_p, rc_p}, e);
        else
          chk({ra_p, rc_p} == e, "R5 R6 boundary record", {ra_p, rc_p}, e);
        got++;
      end
      last_addr = addr_out; last_oe = addr_oe;
      v_p = rec_valid; ra_p = rec_addr; rc_p = rec_cs; ad_p = addr_out;
    end
    cs_in = (addr_oe && sc >= int'(settle_cycles)) ? dec(addr_out, mode, key)
                                                   : ~dec(addr_out, mode, key);
  end

  initial forever begin
    @(negedge clk);
    rec_ready = ($urandom_range(0, 99) < ready_pct);
  end

  task automatic summary_and_end();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary_and_end();
  end

  task automatic disarm();
    @(negedge clk);
    arm = 1'b0;
    @(posedge clk); #2;
    chk(!addr_oe && !done && !rec_valid, "R1 R8 release on disarm",
        {addr_oe, done, rec_valid}, 0);
  endtask

  task automatic run_single(input int m, input int unsigned k, input int st, input int rp);
    int n;
    @(negedge clk);
    mode = m; key = k; settle_cycles = SW'(st); continuous = 1'b0; ready_pct = rp;
    build_expected();
    n = exp_q.size();
    got = 0;
    repeat (3) @(negedge clk);
    arm = 1'b1;
    for (int i = 0; i < 60000 && !done; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(got == n, "R5 record count", got, n);
    chk(done == 1'b1, "R8 done raised", done, 1);
    chk(addr_oe && addr_out == '1 && !rec_valid, "R8 stopped at all ones",
        {addr_oe, addr_out, rec_valid}, {1'b1, {AW{1'b1}}, 1'b0});
    disarm();
  endtask

  task automatic run_continuous(input int m, input int unsigned k, input int st, input int rp);
    int n;
    @(negedge clk);
    mode = m; key = k; settle_cycles = SW'(st); continuous = 1'b1; ready_pct = rp;
    build_expected();
    n = exp_q.size();
    got = 0;
    repeat (3) @(negedge clk);
    arm = 1'b1;
    for (int i = 0; i < 90000 && got < n + 2; i++) @(negedge clk);
    chk(got >= n + 2, "R9 second sweep records", got, n + 2);
    chk(done == 1'b1, "R9 done during continuous", done, 1);
    ready_pct = 100;
    repeat (2) @(negedge clk);
    disarm();
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (2) @(negedge clk);
    chk(!addr_oe && !rec_valid && !done, "R10 state during reset", {addr_oe, rec_valid, done}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(!addr_oe && !rec_valid && !done, "R10 R1 idle after reset", {addr_oe, rec_valid, done}, 0);
    // directed map, settle 2, slow consumer
    run_single(0, 0, 2, 30);
    // constant select pattern: a single record
    run_single(2, 0, 0, 100);
    // random region maps, mixed settle times and consumer rates
    for (int r = 0; r < 2; r++) run_single(1, $urandom, $urandom_range(0, 3), $urandom_range(20, 100));
    // continuous wrap with long settle
    run_continuous(0, 0, 5, 60);
    summary_and_end();
  end
endmodule